// File: doc/BRIEF.md
# Controller Queue Threshold and Interrupt Unit

This unit sits beside the command, response and in-band-interrupt status queues and the transmit and receive data FIFOs of a serial bus controller. It takes an occupancy count from each of them and compares it with programmable thresholds. The results are level-sensitive status flags, a combined interrupt, DMA requests for the data FIFOs, and two permits that tell the bus engine when a transmit or receive transfer may begin.

Eight 8-bit thresholds are held in two write-only registers. Software programs them through a simple write port. A mode input steers the data FIFO thresholds either to PIO status flags or to DMA requests.

The unit also watches the stream of incoming in-band-interrupt data beats. It marks the beat that closes each chunk of the programmed size, so that each chunk can be reported as its own status entry while later data is still arriving.

Top module: `ctrl_queue_thresholds`

## Requirements
- R1: `sts[0]` (command slots available) is high exactly when `cmd_free` is at least the effective command empty-space threshold. This threshold is register 0, bits [7:0].
- R2: `sts[1]` (responses ready) is high exactly when `resp_used` is at least the effective response threshold. This threshold is register 0, bits [15:8].
- R3: `sts[2]` (interrupt status level) is high exactly when `ibi_stat_used` is at least the effective interrupt-status threshold. This threshold is register 0, bits [31:24].
- R4: `ibi_chunk_cut` is high, in the same cycle, on an `ibi_beat` that either brings the running beat count of the current chunk up to the effective chunk size (register 0, bits [23:16]) or carries `ibi_last`. The count restarts at zero after a cut and is unchanged in cycles without a beat.
- R5: `tx_start_ok` is high exactly when `tx_used` is at least the effective transmit-start threshold. This threshold is register 1, bits [23:16].
- R6: `rx_start_ok` is high exactly when `rx_free` is at least the effective receive-start threshold. This threshold is register 1, bits [31:24].
- R7: With `dma_mode` low, the following hold:
  - `sts[3]` is high exactly when `tx_free` is at least the effective transmit empty-space threshold (register 1, bits [7:0]).
  - `sts[4]` is high exactly when `rx_used` is at least the effective receive fill threshold (register 1, bits [15:8]).
  - Both DMA requests are low.
- R8: With `dma_mode` high, `tx_dma_req` and `rx_dma_req` follow the two conditions of R7, and `sts[3]` and `sts[4]` are forced low.
- R9: A threshold field written as zero behaves as one, so no flag, permit, request or cut fires on an empty count.
- R10: `irq` is the OR of `sts & irq_en`.
- R11: Reset sets every threshold to one. A write (`reg_wr_sel` 0 = register 0, 1 = register 1) takes effect in the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Threshold register write strobe |
| reg_wr_sel | input | 1 | 0: queue threshold register, 1: data buffer threshold register |
| reg_wr_data | input | 32 | Four 8-bit threshold fields |
| dma_mode | input | 1 | Routes data FIFO thresholds to DMA requests when high |
| irq_en | input | 5 | Per-flag interrupt enables |
| cmd_free | input | 9 | Empty command queue slots |
| resp_used | input | 9 | Filled response queue entries |
| ibi_stat_used | input | 9 | Filled interrupt status entries |
| tx_used | input | 9 | Filled transmit FIFO entries |
| tx_free | input | 9 | Empty transmit FIFO entries |
| rx_used | input | 9 | Filled receive FIFO entries |
| rx_free | input | 9 | Empty receive FIFO entries |
| ibi_beat | input | 1 | One incoming interrupt data beat this cycle |
| ibi_last | input | 1 | The beat is the last of its interrupt |
| sts | output | 5 | Level status flags: cmd, resp, ibi, tx, rx |
| irq | output | 1 | Combined enabled interrupt |
| tx_dma_req | output | 1 | Transmit FIFO DMA request |
| rx_dma_req | output | 1 | Receive FIFO DMA request |
| tx_start_ok | output | 1 | Transmit transfer may start |
| rx_start_ok | output | 1 | Receive transfer may start or read may be acknowledged |
| ibi_chunk_cut | output | 1 | This beat closes a data chunk |

## Verification
Random occupancies in 0 to 20 are set against random thresholds in 0 to 15. This hits both sides of every compare, as well as the equality point that separates "at least" from "greater than".

Zero-valued thresholds are mixed in, to tell the floor-of-one rule apart from a plain compare. The mode and enables are toggled each vector, which exposes any swap between PIO flags and DMA requests.

Interrupt data beats arrive sparsely with occasional last markers. This separates a size-reached cut from an end-of-interrupt cut. Directed writes check the reset values and that a write becomes visible one edge later.

// File: rtl/ctrl_queue_thresholds.sv
module ctrl_queue_thresholds #(
  parameter int TH_W  = 8,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [4*TH_W-1:0] reg_wr_data,
  input  logic              dma_mode,
  input  logic [4:0]        irq_en,
  input  logic [CNT_W-1:0]  cmd_free,
  input  logic [CNT_W-1:0]  resp_used,
  input  logic [CNT_W-1:0]  ibi_stat_used,
  input  logic [CNT_W-1:0]  tx_used,
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  rx_used,
  input  logic [CNT_W-1:0]  rx_free,
  input  logic              ibi_beat,
  input  logic              ibi_last,
  output logic [4:0]        sts,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              tx_start_ok,
  output logic              rx_start_ok,
  output logic              ibi_chunk_cut
);
  localparam logic [TH_W-1:0] ONE = TH_W'(1);

  logic [TH_W-1:0] th_cmd, th_resp, th_chunk, th_ista;
  logic [TH_W-1:0] th_txe, th_rxf, th_txs, th_rxs;
  logic [TH_W-1:0] chunk_cnt;

  function automatic logic reaches(input logic [CNT_W-1:0] n, input logic [TH_W-1:0] t);
    return n >= CNT_W'((t == '0) ? ONE : t);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {th_ista, th_chunk, th_resp, th_cmd} <= {4{ONE}};
      {th_rxs, th_txs, th_rxf, th_txe}     <= {4{ONE}};
    end else if (reg_wr_en) begin
      if (!reg_wr_sel) {th_ista, th_chunk, th_resp, th_cmd} <= reg_wr_data;
      else             {th_rxs, th_txs, th_rxf, th_txe}     <= reg_wr_data;
    end
  end

  logic tx_lvl, rx_lvl;
  assign tx_lvl = reaches(tx_free, th_txe);
  assign rx_lvl = reaches(rx_used, th_rxf);

  assign sts[0] = reaches(cmd_free, th_cmd);
  assign sts[1] = reaches(resp_used, th_resp);
  assign sts[2] = reaches(ibi_stat_used, th_ista);
  assign sts[3] = tx_lvl && !dma_mode;
  assign sts[4] = rx_lvl && !dma_mode;
  assign tx_dma_req = tx_lvl && dma_mode;
  assign rx_dma_req = rx_lvl && dma_mode;
  assign irq = |(sts & irq_en);

  assign tx_start_ok = reaches(tx_used, th_txs);
  assign rx_start_ok = reaches(rx_free, th_rxs);

  logic [TH_W:0] cnt_next;
  assign cnt_next = {1'b0, chunk_cnt} + 1'b1;
  assign ibi_chunk_cut = ibi_beat &&
    (ibi_last || cnt_next >= {1'b0, (th_chunk == '0) ? ONE : th_chunk});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             chunk_cnt <= '0;
    else if (ibi_chunk_cut) chunk_cnt <= '0;
    else if (ibi_beat)      chunk_cnt <= cnt_next[TH_W-1:0];
  end

  a_r8_dma_masks_pio: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> (sts[4:3] == 2'b00));
  a_r7_pio_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> (!tx_dma_req && !rx_dma_req));
  a_r9_empty_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_used == '0) |-> (!sts[1] && !ibi_chunk_cut || ibi_beat));
  a_r5_tx_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_used == '0) |-> !tx_start_ok);
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|sts));
  a_r4_last_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (ibi_beat && ibi_last) |-> ibi_chunk_cut);
  a_r4_no_beat_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    !ibi_beat |-> !ibi_chunk_cut);
  a_r11_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_sel && reg_wr_data[15:8] != '0) |=>
    (sts[1] == (resp_used >= CNT_W'($past(reg_wr_data[15:8])))));
endmodule

// File: tb/tb_ctrl_queue_thresholds.sv
module tb_ctrl_queue_thresholds;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0, reg_wr_sel = 0, dma_mode = 0, ibi_beat = 0, ibi_last = 0;
  logic [31:0] reg_wr_data = '0;
  logic [4:0] irq_en = '0;
  logic [8:0] cmd_free = 0, resp_used = 0, ibi_stat_used = 0, tx_used = 0, tx_free = 0, rx_used = 0, rx_free = 0;
  logic [4:0] sts;
  logic irq, tx_dma_req, rx_dma_req, tx_start_ok, rx_start_ok, ibi_chunk_cut;

  ctrl_queue_thresholds dut (.*);

  always #2ns clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int th [8];
  int cnt = 0;

  function automatic int eff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    int e_tx = (tx_free >= eff(th[4])) ? 1 : 0;
    int e_rx = (rx_used >= eff(th[5])) ? 1 : 0;
    int e_sts = ((cmd_free >= eff(th[0])) ? 1 : 0) | ((resp_used >= eff(th[1])) ? 2 : 0)
              | ((ibi_stat_used >= eff(th[3])) ? 4 : 0)
              | (dma_mode ? 0 : (e_tx << 3) | (e_rx << 4));
    chk("R1/R2/R3/R7/R9 sts", int'(sts), e_sts);
    chk("R8 tx_dma_req", int'(tx_dma_req), dma_mode ? e_tx : 0);
    chk("R8 rx_dma_req", int'(rx_dma_req), dma_mode ? e_rx : 0);
    chk("R10 irq", int'(irq), ((e_sts & int'(irq_en)) != 0) ? 1 : 0);
    chk("R5 tx_start_ok", int'(tx_start_ok), (tx_used >= eff(th[6])) ? 1 : 0);
    chk("R6 rx_start_ok", int'(rx_start_ok), (rx_free >= eff(th[7])) ? 1 : 0);
    chk("R4 ibi_chunk_cut", int'(ibi_chunk_cut),
        (ibi_beat && (ibi_last || cnt + 1 >= eff(th[2]))) ? 1 : 0);
  endtask

  task automatic step();
    bit cut;
    #1ns check_all();
    cut = ibi_beat && (ibi_last || cnt + 1 >= eff(th[2]));
    @(posedge clk);
    if (reg_wr_en)
      for (int i = 0; i < 4; i++) th[(reg_wr_sel ? 4 : 0) + i] = int'(reg_wr_data[8*i +: 8]);
    if (cut) cnt = 0; else if (ibi_beat) cnt++;
    @(negedge clk);
  endtask

  initial begin
    #20us;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    for (int i = 0; i < 8; i++) th[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset values: every threshold one
    cmd_free = 1; irq_en = 5'h1f;
    step();
    cmd_free = 0;
    step();
    // R11 write takes effect next cycle; R9 zero acts as one
    reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = {8'd3, 8'd0, 8'd5, 8'd0};
    resp_used = 4; cmd_free = 1;
    step();
    reg_wr_en = 0;
    step();
    resp_used = 5; step();
    // R4 directed: chunk of 3? set data chunk to 2
    reg_wr_en = 1; reg_wr_data = {8'd3, 8'd2, 8'd5, 8'd0}; step(); reg_wr_en = 0;
    ibi_beat = 1; step(); step(); step(); ibi_last = 1; step(); ibi_last = 0; ibi_beat = 0; step();
    for (int v = 0; v < 3000; v++) begin
      reg_wr_en = ($urandom % 8) == 0;
      reg_wr_sel = $urandom % 2;
      for (int i = 0; i < 4; i++) reg_wr_data[8*i +: 8] = 8'($urandom % 16);
      dma_mode = $urandom % 2;
      irq_en = 5'($urandom);
      cmd_free = 9'($urandom % 21); resp_used = 9'($urandom % 21);
      ibi_stat_used = 9'($urandom % 21); tx_used = 9'($urandom % 21);
      tx_free = 9'($urandom % 21); rx_used = 9'($urandom % 21);
      rx_free = 9'($urandom % 21);
      ibi_beat = ($urandom % 3) != 0;
      ibi_last = ($urandom % 7) == 0;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule